// File: doc/BRIEF.md
# Secured Configuration Store with User Signature

This block keeps the configuration image of a small programmable logic device: a functional fuse array of 5828 bits, a 64-bit user signature and one lock bit. A controller drives it through a word-wide command port carrying an opcode, a word address and a 32-bit data word. Readback returns one registered word one cycle after the command is accepted.

Programming always starts with a bulk erase. One start command erases the whole image, including the signature. The other start command erases only the functional array, so a functional-only load keeps the signature it already holds. Both start commands clear the lock bit, and that is the only way to clear it. While the lock is set, reads of the functional array return zeros and raise a denial flag. The signature stays readable at all times. While an erase sweep or a word program is in progress, a busy output is high and every command is dropped.

Reset stands for a blank, erased part: every cell is zero and the lock is clear.

Top module: `cfg_store`

## Requirements
- R1: After reset, busy, session_open, locked, rd_valid, rd_data and rd_denied are all 0, and every word reads back as 0.
- R2: Word map. Functional fuse n sits in word n/32 at bit n%32 (words 0 to 182). Word 182 holds only 4 valid bits; its bits 31:4 always read 0. The signature occupies word 183 (bytes 0 to 3) and word 184 (bytes 4 to 7): signature byte k is at bits 8(k%4)+7 down to 8(k%4), with the lowest fuse address of the byte in the least significant bit. Addresses 185 and above read 0 and are never written.
- R3: A read (opcode 1) accepted at a clock edge gives rd_valid = 1 for exactly the following cycle, with rd_data equal to the addressed word. rd_data is 0 whenever rd_valid is 0.
- R4: While locked = 1, a read of words 0 to 182 returns rd_data = 0 with rd_denied = 1. A read of words 183 or 184 returns the stored signature with rd_denied = 0, whatever the lock holds.
- R5: A full start (opcode 3) clears every word including the signature, clears the lock, opens the session and holds busy high for 185 cycles after the accepting edge.
- R6: A functional start (opcode 2) behaves like R5 but leaves words 183 and 184 unchanged.
- R7: A write (opcode 4) stores cmd_wdata at cmd_addr only while a session is open, then holds busy for PROG_CYCLES (2) cycles. Writes in a functional-only session leave the signature unchanged. Writes with no session open are dropped entirely and do not raise busy.
- R8: The end command (opcode 5) closes the session. The lock command (opcode 6) sets the lock. Only opcodes 2 and 3 clear the lock. Opcodes 0 and 7 do nothing.
- R9: Any command presented while busy = 1 is dropped: it has no effect on memory, the lock, the session or the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (blank device) |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 1 read, 2 functional start, 3 full start, 4 write, 5 end, 6 lock |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 32 | Write data |
| busy | output | 1 | Erase sweep or word program in progress |
| session_open | output | 1 | Programming session open (from a start until end) |
| locked | output | 1 | Lock bit |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| rd_denied | output | 1 | Read was blocked by the lock |

## Verification
The hardest situation to reach is a locked part that still holds a signature which must survive a functional-only reload. Reaching it takes four phases in order: a full erase, programming of both regions, locking, and then a functional start. The bench drives exactly that chain. Along the way it fires reads, writes and lock commands in the middle of the 185-cycle erase sweep and the two-cycle program window, and it tries signature writes inside the functional-only session. A behavioural model with a flat word array and a busy countdown predicts every output on every cycle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_BEGF  = 3'd2,
        OP_BEGA  = 3'd3,
        OP_WRITE = 3'd4,
        OP_END   = 3'd5,
        OP_LOCK  = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_OPEN  = 2'd2,
        ST_PROG  = 2'd3
    } st_e;

endpackage

// File: rtl/cfg_array.sv
module cfg_array #(
    parameter int WORD_W     = 32,
    parameter int TOT_WORDS  = 185,
    parameter int FUNC_WORDS = 183,
    parameter int LAST_BITS  = 4,
    parameter int AW         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam logic [WORD_W-1:0] LAST_MASK = {WORD_W{1'b1}} >> (WORD_W - LAST_BITS);
    localparam logic [AW-1:0]     LAST_FUNC = AW'(FUNC_WORDS - 1);
    localparam logic [AW-1:0]     TOP_ADDR  = AW'(TOT_WORDS - 1);

    logic [WORD_W-1:0] mem_q [TOT_WORDS];
    logic [WORD_W-1:0] word_d;
    logic              wr_ok;

    // Next word value: the partial last functional word keeps only its valid bits.
    always_comb begin
        wr_ok  = we && (waddr <= TOP_ADDR);
        word_d = (waddr == LAST_FUNC) ? (wdata & LAST_MASK) : wdata;
    end

    // Reset models a blank, erased part.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOT_WORDS; i++) mem_q[i] <= '0;
        end else if (wr_ok) begin
            mem_q[int'(waddr)] <= word_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr <= TOP_ADDR) rdata = mem_q[int'(raddr)];
    end

    p_last_word_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && waddr == LAST_FUNC) |=> ((mem_q[int'(LAST_FUNC)] & ~LAST_MASK) == '0))
        else $error("p_last_word_mask_r2");

    p_write_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr > TOP_ADDR) |-> (rdata == '0))
        else $error("p_write_in_range_r2");

endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
    import cfg_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int TOT_WORDS   = 185,
    parameter int FUNC_WORDS  = 183,
    parameter int PROG_CYCLES = 2,
    parameter int AW          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic              arr_we,
    output logic [AW-1:0]     arr_waddr,
    output logic [WORD_W-1:0] arr_wdata,
    output logic              busy,
    output logic              session_open,
    output logic              locked,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_denied
);
    localparam int            CW        = $clog2(PROG_CYCLES + 1);
    localparam logic [AW-1:0] FUNC_END  = AW'(FUNC_WORDS);
    localparam logic [AW-1:0] TOP_ADDR  = AW'(TOT_WORDS - 1);
    localparam logic [CW-1:0] PROG_LOAD = CW'(PROG_CYCLES - 1);

    typedef struct packed {
        st_e               st;
        logic              full;
        logic [AW-1:0]     ptr;
        logic [CW-1:0]     cnt;
        logic              lock;
        logic              rvalid;
        logic [WORD_W-1:0] rdata;
        logic              denied;
    } ctrl_s;

    ctrl_s r_d, r_q;
    logic  accept;
    logic  in_func, in_sig;

    always_comb begin
        r_d          = r_q;
        r_d.rvalid   = 1'b0;
        r_d.rdata    = '0;
        r_d.denied   = 1'b0;
        arr_we       = 1'b0;
        arr_waddr    = r_q.ptr;
        arr_wdata    = '0;
        in_func      = cmd_addr < FUNC_END;
        in_sig       = !in_func && (cmd_addr <= TOP_ADDR);
        accept       = cmd_valid && (r_q.st == ST_IDLE || r_q.st == ST_OPEN);

        unique case (r_q.st)
            ST_ERASE: begin
                // One word cleared per cycle; signature skipped in a functional-only sweep.
                arr_we = (r_q.ptr < FUNC_END) || r_q.full;
                if (r_q.ptr == TOP_ADDR) r_d.st  = ST_OPEN;
                else                     r_d.ptr = r_q.ptr + 1'b1;
            end
            ST_PROG: begin
                if (r_q.cnt == '0) r_d.st  = ST_OPEN;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: ;
        endcase

        if (accept) begin
            unique case (op_e'(cmd_op))
                OP_READ: begin
                    r_d.rvalid = 1'b1;
                    if (in_func && r_q.lock) r_d.denied = 1'b1;
                    else if (in_func || in_sig) r_d.rdata = arr_rdata;
                end
                OP_BEGF, OP_BEGA: begin
                    r_d.st   = ST_ERASE;
                    r_d.ptr  = '0;
                    r_d.lock = 1'b0;
                    r_d.full = (op_e'(cmd_op) == OP_BEGA);
                end
                OP_WRITE: begin
                    if (r_q.st == ST_OPEN) begin
                        arr_waddr = cmd_addr;
                        arr_wdata = cmd_wdata;
                        arr_we    = in_func || (in_sig && r_q.full);
                        r_d.st    = ST_PROG;
                        r_d.cnt   = PROG_LOAD;
                    end
                end
                OP_END:  if (r_q.st == ST_OPEN) r_d.st = ST_IDLE;
                OP_LOCK: r_d.lock = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st == ST_ERASE) || (r_q.st == ST_PROG);
    assign session_open = (r_q.st != ST_IDLE);
    assign locked       = r_q.lock;
    assign rd_valid     = r_q.rvalid;
    assign rd_data      = r_q.rdata;
    assign rd_denied    = r_q.denied;

    p_denied_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_denied |-> (rd_valid && rd_data == '0))
        else $error("p_denied_zero_r4");

    p_idle_data_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && !rd_denied))
        else $error("p_idle_data_zero_r3");

    p_no_read_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid)
        else $error("p_no_read_when_busy_r9");

    p_lock_clear_by_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (r_q.st == ST_ERASE && r_q.ptr == '0))
        else $error("p_lock_clear_by_erase_r8");

    p_sig_kept_func_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && arr_waddr >= FUNC_END) |-> r_q.full)
        else $error("p_sig_kept_func_r6");

    p_prog_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG) |-> (r_q.cnt <= PROG_LOAD))
        else $error("p_prog_window_r7");

    p_erase_ends_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ERASE && r_q.ptr == TOP_ADDR) |=> (!busy && session_open))
        else $error("p_erase_ends_open_r5");

endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
    parameter int FUNC_BITS   = 5828,
    parameter int SIG_BITS    = 64,
    parameter int WORD_W      = 32,
    parameter int PROG_CYCLES = 2,
    parameter int FUNC_WORDS  = (FUNC_BITS + WORD_W - 1) / WORD_W,
    parameter int SIG_WORDS   = SIG_BITS / WORD_W,
    parameter int TOT_WORDS   = FUNC_WORDS + SIG_WORDS,
    parameter int AW          = $clog2(TOT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              session_open,
    output logic              locked,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_denied
);
    localparam int LAST_BITS = FUNC_BITS - (FUNC_WORDS - 1) * WORD_W;

    logic              arr_we;
    logic [AW-1:0]     arr_waddr;
    logic [WORD_W-1:0] arr_wdata;
    logic [WORD_W-1:0] arr_rdata;

    cfg_array #(
        .WORD_W(WORD_W), .TOT_WORDS(TOT_WORDS), .FUNC_WORDS(FUNC_WORDS),
        .LAST_BITS(LAST_BITS), .AW(AW)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr),
        .wdata(arr_wdata), .raddr(cmd_addr), .rdata(arr_rdata)
    );

    cfg_ctrl #(
        .WORD_W(WORD_W), .TOT_WORDS(TOT_WORDS), .FUNC_WORDS(FUNC_WORDS),
        .PROG_CYCLES(PROG_CYCLES), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .arr_rdata(arr_rdata),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .busy(busy), .session_open(session_open), .locked(locked),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_denied(rd_denied)
    );

endmodule

// File: tb/tb_cfg_store.sv
module tb_cfg_store;
    localparam int FW = 183;
    localparam int TW = 185;
    localparam int PC = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic [2:0]  cmd_op = 0;
    logic [7:0]  cmd_addr = 0;
    logic [31:0] cmd_wdata = 0;
    logic        busy, session_open, locked, rd_valid, rd_denied;
    logic [31:0] rd_data;

    always #4 clk = ~clk;

    cfg_store dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
        .session_open(session_open), .locked(locked), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_denied(rd_denied)
    );

    // Behavioural reference model
    logic [31:0] m_mem [TW];
    int          m_busy = 0;
    bit          m_open = 0, m_full = 0, m_lock = 0, m_rv = 0, m_den = 0;
    logic [31:0] m_rd = 0;

    int    vectors = 0;
    int    errors = 0;
    string tag = "R1";

    task automatic model_step(bit v, logic [2:0] op, logic [7:0] a, logic [31:0] d);
        bit acc;
        acc = v && (m_busy == 0);
        if (m_busy > 0) m_busy--;
        m_rv = 0; m_rd = 0; m_den = 0;
        if (acc) begin
            case (op)
                3'd1: begin
                    m_rv = 1;
                    if (a < FW) begin
                        if (m_lock) m_den = 1; else m_rd = m_mem[a];
                    end else if (a < TW) m_rd = m_mem[a];
                end
                3'd2, 3'd3: begin
                    for (int i = 0; i < TW; i++)
                        if (i < FW || op == 3'd3) m_mem[i] = 0;
                    m_lock = 0; m_open = 1; m_full = (op == 3'd3); m_busy = TW;
                end
                3'd4: if (m_open) begin
                    if (a < FW) m_mem[a] = (a == FW - 1) ? (d & 32'hF) : d;
                    else if (a < TW && m_full) m_mem[a] = d;
                    m_busy = PC;
                end
                3'd5: m_open = 0;
                3'd6: m_lock = 1;
                default: ;
            endcase
        end
    endtask

    task automatic cmp(string name, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, name, got, exp);
        end
    endtask

    task automatic compare_all();
        cmp("busy", {31'd0, busy}, {31'd0, m_busy > 0});
        cmp("session_open", {31'd0, session_open}, {31'd0, m_open});
        cmp("locked", {31'd0, locked}, {31'd0, m_lock});
        cmp("rd_valid", {31'd0, rd_valid}, {31'd0, m_rv});
        cmp("rd_data", rd_data, m_rd);
        cmp("rd_denied", {31'd0, rd_denied}, {31'd0, m_den});
    endtask

    task automatic step(bit v, logic [2:0] op, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(posedge clk);
        #1;
        model_step(v, op, a, d);
        compare_all();
    endtask

    task automatic idle_until_free();
        while (m_busy > 0) step(0, 0, 0, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic rd(logic [7:0] a);
        step(1, 3'd1, a, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(1, 3'd4, a, d);
        idle_until_free();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in %s", tag);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < TW; i++) m_mem[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        compare_all();                       // R1 reset state
        @(negedge clk);
        rst_n = 1;
        tag = "R1";
        rd(0); rd(182); rd(183); rd(184);

        tag = "R7";                          // write with no session open: dropped
        step(1, 3'd4, 5, 32'hDEADBEEF);
        rd(5);

        tag = "R5";
        step(1, 3'd3, 0, 0);
        tag = "R9";                          // commands during erase sweep
        step(1, 3'd1, 0, 0);
        step(1, 3'd6, 0, 0);
        step(1, 3'd4, 1, 32'h1234);
        step(1, 3'd5, 0, 0);
        tag = "R5";
        idle_until_free();

        tag = "R2";
        step(1, 3'd4, 0, 32'hA5A5_0001);
        tag = "R9";                          // write during program window
        step(1, 3'd4, 7, 32'hFFFF_FFFF);
        tag = "R2";
        idle_until_free();
        wr(1, 32'h0102_0304);
        wr(100, 32'hCAFE_F00D);
        wr(182, 32'hFFFF_FFFF);
        wr(183, 32'h4433_2211);
        wr(184, 32'h8877_6655);
        wr(200, 32'h1111_1111);
        tag = "R3";
        rd(0); rd(1); rd(7); rd(100); rd(182); rd(183); rd(184); rd(200); rd(255);

        tag = "R8";
        step(1, 3'd5, 0, 0);
        step(1, 3'd6, 0, 0);
        step(1, 3'd0, 0, 0);
        step(1, 3'd7, 0, 0);
        tag = "R4";
        rd(0); rd(100); rd(182); rd(183); rd(184); rd(190);

        tag = "R6";
        step(1, 3'd2, 0, 0);
        idle_until_free();
        rd(0); rd(100); rd(183); rd(184);
        tag = "R7";
        wr(183, 32'h0BAD_0BAD);
        wr(3, 32'h3333_3333);
        rd(183); rd(3);
        tag = "R8";
        step(1, 3'd6, 0, 0);
        rd(3); rd(184);
        step(1, 3'd5, 0, 0);
        rd(3);

        tag = "R3";
        step(1, 3'd3, 0, 0);
        idle_until_free();
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr(8'(lfsr[15:8] % 8'd186), lfsr);
            rd(8'(lfsr[23:16] % 8'd186));
        end
        for (int k = 0; k < TW; k++) rd(8'(k));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule